// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block sits between a UART transmit shifter and an infrared LED driver. It turns the NRZ transmit bit stream into a return-to-zero pulse stream. A zero bit becomes a short high pulse. A one bit leaves the line dark. The line rests low whenever nothing is being sent. The encoder follows bit boundaries by counting the sixteen oversampling ticks that make up each bit period. The first tick seen after the encoder becomes active opens a bit.

Two pulse-width modes are available:
- **Normal mode:** the pulse lasts three oversampling ticks, which is 3/16 of a bit period.
- **Low-power mode:** the pulse lasts three periods of a slow clock. That clock is made by dividing the system clock by an 8-bit prescaler value, so the pulse width does not depend on the baud rate.

A prescaler of zero, or a low enable, parks the encoder with its output low. Because the infrared link is half duplex, a busy flag from the receive side suppresses encoding. The flag is looked at only at the start of each bit, so a pulse that has already been committed always finishes.

Top module: `sir_pulse_encoder`

## Requirements
- R1: A bit with tx_bit=0 produces a high pulse on ir_out. A bit with tx_bit=1 produces none. ir_out is low from the first clock after the bit-start tick of a one bit.
- R2: During reset and after reset with no zero bit sent, ir_out is low.
- R3: With lowpwr_sel=0, a zero bit drives ir_out high from the clock edge that samples the bit's first tick. It drops on the edge that samples the fourth tick, so the pulse is 3 tick periods wide (12 clocks when ticks come every 4 clocks).
- R4: With lowpwr_sel=1, the pulse starts at the first divided-clock edge at or after the bit start. That edge comes within psc_div clocks of the start. The pulse lasts exactly 3*psc_div clocks.
- R5: A low-power pulse still high at the next bit boundary is ended at that boundary. A following one bit then shows no high clock at all.
- R6: With psc_div=0, ir_out stays low for any input.
- R7: With enc_en=0, ir_out stays low. The bit phase restarts, so the first tick after re-enabling opens a new bit.
- R8: If rx_busy is 1 at a bit's first tick, that bit produces no pulse, even for tx_bit=0.
- R9: rx_busy is sampled only at the bit start. Raising it later in the bit does not shorten or cancel a pulse already committed.
- R10: Bit boundaries fall on every 16th tick16 pulse, counting the first tick after activation as a boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low synchronous reset |
| enc_en | input | 1 | Encoder enable |
| lowpwr_sel | input | 1 | 0: pulse of 3 ticks; 1: pulse of 3 divided-clock periods |
| psc_div | input | PSC_W | System-clock divisor for the low-power clock; 0 disables the encoder |
| tick16 | input | 1 | One-clock pulse at 16 times the baud rate |
| tx_bit | input | 1 | NRZ transmit bit from the UART shifter |
| rx_busy | input | 1 | Receive path is taking in a frame |
| ir_out | output | 1 | Pulse output to the LED driver, active high |

## Verification
The assertions take several things for granted about the inputs:
- tick16 is a single-clock strobe.
- tx_bit changes only at a bit boundary.
- lowpwr_sel and psc_div are held steady while the encoder is enabled.

Under those conditions, each pulse rises only on a unit event and falls only after three of them, or at a boundary or a disable. The stimulus changes mode and prescaler only while enc_en is low. It raises tick16 for exactly one clock in every four, and it moves tx_bit only in the clock of a bit's first tick.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;

  // Divider wraps when the next count would reach the divisor.
  function automatic logic div_wrap(input logic [31:0] cnt, input logic [31:0] div);
    return (cnt + 32'd1) >= div;
  endfunction

  // Oversampling phase wraps after the last tick of a bit.
  function automatic logic phase_wrap(input logic [31:0] ph, input logic [31:0] ovs);
    return ph == (ovs - 32'd1);
  endfunction

  // True on the unit that ends a running pulse.
  function automatic logic last_unit(input logic [31:0] left);
    return left == 32'd1;
  endfunction

endpackage

// File: rtl/sir_bit_phase.sv
module sir_bit_phase #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic bit_start
);
  import sir_enc_pkg::*;
  localparam int PH_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [PH_W-1:0] phase_q;

  assign bit_start = active && tick && (phase_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!active) begin
      phase_q <= '0;
    end else if (tick) begin
      if (phase_wrap(32'(phase_q), 32'(OVS)))
        phase_q <= '0;
      else
        phase_q <= phase_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/sir_lp_divider.sv
module sir_lp_divider #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [PSC_W-1:0] div,
  output logic             lp_edge
);
  import sir_enc_pkg::*;

  logic [PSC_W-1:0] cnt_q;
  logic             wrap;

  assign wrap    = div_wrap(32'(cnt_q), 32'(div));
  assign lp_edge = active && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PSC_W'(1);
    end
  end
endmodule

// File: rtl/sir_pulse_shaper.sv
module sir_pulse_shaper #(
  parameter int UNITS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_start,
  input  logic unit_evt,
  input  logic arm_now,
  output logic pulse_q
);
  import sir_enc_pkg::*;
  localparam int CNT_W = $clog2(UNITS + 1);

  logic             pend_q;
  logic [CNT_W-1:0] left_q;
  logic             fire;

  assign fire = unit_evt && (bit_start ? arm_now : pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      pend_q  <= 1'b0;
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (bit_start) begin
        pend_q  <= arm_now;
        left_q  <= '0;
        pulse_q <= 1'b0;
      end
      if (fire) begin
        pend_q  <= 1'b0;
        left_q  <= CNT_W'(UNITS);
        pulse_q <= 1'b1;
      end else if (!bit_start && unit_evt && (left_q != '0)) begin
        left_q <= left_q - CNT_W'(1);
        if (last_unit(32'(left_q)))
          pulse_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sir_pulse_encoder.sv
module sir_pulse_encoder #(
  parameter int PSC_W       = 8,
  parameter int OVS         = 16,
  parameter int PULSE_UNITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_en,
  input  logic             lowpwr_sel,
  input  logic [PSC_W-1:0] psc_div,
  input  logic             tick16,
  input  logic             tx_bit,
  input  logic             rx_busy,
  output logic             ir_out
);
  logic active;
  logic bit_start;
  logic lp_edge;
  logic unit_evt;
  logic arm_now;
  logic pulse_q;

  assign active   = enc_en && (psc_div != '0);
  assign unit_evt = lowpwr_sel ? lp_edge : (active && tick16);
  assign arm_now  = !tx_bit && !rx_busy;
  assign ir_out   = pulse_q;

  sir_bit_phase #(.OVS(OVS)) u_phase (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(tick16), .bit_start(bit_start)
  );

  sir_lp_divider #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .active(active), .div(psc_div), .lp_edge(lp_edge)
  );

  sir_pulse_shaper #(.UNITS(PULSE_UNITS)) u_shape (
    .clk(clk), .rst_n(rst_n), .active(active), .bit_start(bit_start),
    .unit_evt(unit_evt), .arm_now(arm_now), .pulse_q(pulse_q)
  );
endmodule

// File: rtl/sir_pulse_encoder_chk.sv
module sir_pulse_encoder_chk #(
  parameter int UNITS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic bit_start,
  input logic unit_evt,
  input logic lowpwr_sel,
  input logic tx_bit,
  input logic rx_busy,
  input logic ir_out
);
  logic [7:0] units_hi;

  always_ff @(posedge clk) begin
    if (!rst_n || !ir_out || bit_start)
      units_hi <= '0;
    else if (unit_evt)
      units_hi <= units_hi + 8'd1;
  end

  // R1 R3
  normal_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start && !lowpwr_sel && !tx_bit && !rx_busy |=> ir_out);

  // R1 R5
  one_bit_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start && tx_bit |=> !ir_out);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start && rx_busy |=> !ir_out);

  // R6 R7
  parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ir_out);

  // R3 R4
  rise_on_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_out) |-> $past(unit_evt));

  // R3 R4
  width_units_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ir_out) && $past(active) && !$past(bit_start) |-> units_hi == 8'(UNITS));

  // R9
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ir_out) |-> ($past(unit_evt) || $past(bit_start) || !$past(active)));
endmodule

bind sir_pulse_encoder sir_pulse_encoder_chk u_chk (.*);

// File: tb/sir_pulse_encoder_test.sv
module sir_pulse_encoder_test;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  typedef struct packed {
    logic       lp;
    logic [7:0] psc;
    logic [7:0] frame;
    logic       busy;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'd1,   8'h55, 1'b0},
    '{1'b0, 8'd200, 8'h00, 1'b0},
    '{1'b0, 8'd7,   8'hA3, 1'b1},
    '{1'b1, 8'd1,   8'h5A, 1'b0},
    '{1'b1, 8'd5,   8'h0F, 1'b0},
    '{1'b1, 8'd15,  8'h81, 1'b0},
    '{1'b0, 8'd0,   8'h00, 1'b0},
    '{1'b1, 8'd0,   8'h00, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_en = 1'b0;
  logic lowpwr_sel = 1'b0;
  logic [7:0] psc_div = 8'd0;
  logic tick16 = 1'b0;
  logic tx_bit = 1'b1;
  logic rx_busy = 1'b0;
  logic ir_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sir_pulse_encoder uut (
    .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .lowpwr_sel(lowpwr_sel),
    .psc_div(psc_div), .tick16(tick16), .tx_bit(tx_bit), .rx_busy(rx_busy),
    .ir_out(ir_out)
  );

  function automatic int exp_width(logic lp, logic [7:0] psc, logic b, logic busy);
    if (psc == 8'd0 || b || busy) return 0;
    return lp ? 3 * int'(psc) : 3 * TICK_DIV;
  endfunction

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bit: 16 ticks, one every TICK_DIV clocks; rx_busy rises at busy_from.
  task automatic run_bit(input logic b, input int busy_from,
                         output int cnt, output int first, output logic last);
    cnt = 0; first = -1; last = 1'b0;
    for (int i = 0; i < BIT_CLKS; i++) begin
      @(negedge clk);
      tick16  = (i % TICK_DIV) == 0;
      tx_bit  = b;
      rx_busy = (i >= busy_from);
      @(posedge clk);
      #1;
      if (ir_out) begin
        cnt++;
        if (first < 0) first = i;
      end
      last = ir_out;
    end
  endtask

  task automatic park(input int n);
    @(negedge clk);
    enc_en = 1'b0; tick16 = 1'b0; rx_busy = 1'b0; tx_bit = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic lp, input logic [7:0] psc, input logic en);
    park(2);
    lowpwr_sel = lp; psc_div = psc;
    @(negedge clk);
    enc_en = en;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt, first;
    logic last;

    // R2: reset holds output low even with zero bits ticking
    enc_en = 1'b1; psc_div = 8'd5; tx_bit = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      tick16 = (i % TICK_DIV) == 0;
      check("R2 reset", ir_out == 1'b0, ir_out, 0);
    end
    setup(1'b0, 8'd5, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 idle after reset", ir_out == 1'b0, ir_out, 0);

    // Table walk: R1 R3 R4 R6 R8 R10
    for (int v = 0; v < 8; v++) begin
      setup(VECS[v].lp, VECS[v].psc, 1'b1);
      for (int k = 0; k < 8; k++) begin
        int e;
        e = exp_width(VECS[v].lp, VECS[v].psc, VECS[v].frame[k], VECS[v].busy);
        run_bit(VECS[v].frame[k], VECS[v].busy ? 0 : BIT_CLKS, cnt, first, last);
        check($sformatf("R1 R3 R4 R6 R8 R10 vec%0d bit%0d width", v, k), cnt == e, cnt, e);
        if (e > 0 && !VECS[v].lp)
          check($sformatf("R3 vec%0d bit%0d onset", v, k), first == 0, first, 0);
        if (e > 0 && VECS[v].lp)
          check($sformatf("R4 vec%0d bit%0d onset", v, k),
                first >= 0 && first < int'(VECS[v].psc), first, int'(VECS[v].psc) - 1);
      end
    end

    // R7: disabled encoder stays dark
    setup(1'b0, 8'd5, 1'b0);
    run_bit(1'b0, BIT_CLKS, cnt, first, last);
    check("R7 disabled", cnt == 0, cnt, 0);

    // R7 R10: drop enable mid-bit, phase restarts on re-enable
    setup(1'b0, 8'd5, 1'b1);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      tick16 = (i % TICK_DIV) == 0;
      tx_bit = 1'b1;
    end
    setup(1'b0, 8'd5, 1'b1);
    run_bit(1'b0, BIT_CLKS, cnt, first, last);
    check("R7 R10 restart width", cnt == 3 * TICK_DIV, cnt, 3 * TICK_DIV);
    check("R7 R10 restart onset", first == 0, first, 0);

    // R5: long low-power pulse cut at boundary
    setup(1'b1, 8'd30, 1'b1);
    run_bit(1'b0, BIT_CLKS, cnt, first, last);
    check("R5 cut width", cnt >= 35 && cnt <= BIT_CLKS, cnt, BIT_CLKS);
    check("R5 high at boundary", last == 1'b1, last, 1);
    run_bit(1'b1, BIT_CLKS, cnt, first, last);
    check("R5 next one bit dark", cnt == 0, cnt, 0);

    // R9: busy raised mid-bit does not cut pulses
    setup(1'b0, 8'd3, 1'b1);
    run_bit(1'b0, 4, cnt, first, last);
    check("R9 normal late busy", cnt == 3 * TICK_DIV, cnt, 3 * TICK_DIV);
    setup(1'b1, 8'd5, 1'b1);
    run_bit(1'b0, 2, cnt, first, last);
    check("R9 lowpwr late busy", cnt == 15, cnt, 15);
    // R8: busy now held across the next bit start
    run_bit(1'b0, 0, cnt, first, last);
    check("R8 busy at start", cnt == 0, cnt, 0);

    park(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule